// File: doc/BRIEF.md
# Placeholder Level-2 Cache Controller Register Block

This block gives system software a register window that looks like a level-2 cache controller while no real cache sits behind it. Boot code can probe the identification and cache-type words, program the enable, auxiliary, latency and address-filter registers, and issue maintenance operations. Every maintenance operation reports itself complete at once, so driver code never waits. The block has no cache storage and generates no memory traffic.

The slave sits on a single-cycle APB-style bus. `pready` is held high. A transfer spends one cycle in the setup phase and one in the access phase. Register writes take effect at the clock edge that ends the access phase. Read data is driven only during the access phase of a read. Only the low 12 bits of the address are decoded. An access to an offset with no function completes with `pslverr` raised.

The cache-type word has an unusual behaviour. Each read of it ORs a pattern built from the auxiliary register into the stored value, keeps the result, and returns it. Bits therefore accumulate over successive reads and are cleared only by reset.

Top module: `l2stub_regblock`

## Requirements
- R1: With `rst` high at a clock edge, the state becomes: enable register 0, auxiliary register 0x02020000, tag-latency, data-latency, filter-start and filter-end registers 0, and cache-type register equal to the parameter `CTYPE_INIT` (default 0x1C100100).
- R2: Only `paddr[11:0]` selects a register. Upper address bits are ignored, and a read at offset 0x000 returns 0x410000C8.
- R3: A write to offset 0x100 (enable register) keeps only bit 0 of `pwdata`. Reads of 0x100 return that bit with bits 31:1 at zero.
- R4: The auxiliary (0x104), tag-latency (0x108), data-latency (0x10C), filter-start (0xC00) and filter-end (0xC00 + 4 = 0xC04) registers store all 32 bits written and read them back unchanged.
- R5: A read at offset 0x004 forms the 5-bit code {aux[19:17], 1'b0, aux[16]}. The code shifted left by 18 and by 6 is ORed into the stored cache-type value. The result is returned and also stored, so its set bits stay set until reset.
- R6: Every offset from 0x730 through 0x7FF reads zero and ignores writes with `pslverr` low. Offsets 0x72C and 0x800 are not part of this range.
- R7: Offsets 0xF40, 0xF60 and 0xF80 read zero and ignore writes with `pslverr` low.
- R8: An access to any offset not named in R2–R7 raises `pslverr` during its access phase, reads zero, and changes no register.
- R9: `pready` is always high. `prdata` and `pslverr` are zero outside the access phase, and `prdata` is zero during write accesses.
- R10: A cycle with `psel` high and `penable` low (setup phase) changes no register, even when `pwrite` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase of a read |
| pready | output | 1 | Transfer complete, held high |
| pslverr | output | 1 | Bad-offset flag during the access phase |

## Verification
The hardest behaviour to reach is the accumulation in the cache-type word. It only shows when several reads are separated by auxiliary-register writes that set different bits of aux[19:16], and then by further writes that clear those bits again. The stimulus interleaves such writes with cache-type reads. The test confirms that no bit drops out of the stored value and that reset alone restores `CTYPE_INIT`. It also walks the edges of the maintenance range (0x72C, 0x730, 0x7FF, 0x800). It drives a setup phase with `pwrite` high and no access phase after it, which must leave the registers untouched.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

    localparam int          OFF_W     = 12;
    localparam logic [31:0] ID_VALUE  = 32'h4100_00C8;
    localparam logic [31:0] AUX_RESET = 32'h0202_0000;

    localparam logic [OFF_W-1:0] OFF_ID      = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CTYPE   = 12'h004;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 12'h100;
    localparam logic [OFF_W-1:0] OFF_AUX     = 12'h104;
    localparam logic [OFF_W-1:0] OFF_TAGLAT  = 12'h108;
    localparam logic [OFF_W-1:0] OFF_DATLAT  = 12'h10C;
    localparam logic [OFF_W-1:0] OFF_FSTART  = 12'hC00;
    localparam logic [OFF_W-1:0] OFF_FEND    = 12'hC04;
    localparam logic [OFF_W-1:0] MAINT_LO    = 12'h730;
    localparam logic [OFF_W-1:0] MAINT_HI    = 12'h800;

    localparam int N_RAZ = 3;
    localparam logic [N_RAZ*OFF_W-1:0] RAZ_LIST = {12'hF80, 12'hF60, 12'hF40};

    typedef enum logic [3:0] {
        RG_ID, RG_CTYPE, RG_ENABLE, RG_AUX, RG_TAGLAT, RG_DATLAT,
        RG_FSTART, RG_FEND, RG_MAINT, RG_RAZ, RG_BAD
    } region_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        region_e     region;
        logic [31:0] wdata;
    } access_t;

    function automatic logic [31:0] ctype_or_mask(input logic [31:0] aux);
        logic [31:0] code;
        code = {27'd0, aux[19:17], 1'b0, aux[16]};
        return (code << 18) | (code << 6);
    endfunction

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
    import l2stub_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    output region_e          region
);

    logic [N_RAZ-1:0] raz_hit;

    for (genvar i = 0; i < N_RAZ; i++) begin : g_raz
        assign raz_hit[i] = (offset == RAZ_LIST[i*OFF_W +: OFF_W]);
    end

    always_comb begin
        if (offset >= MAINT_LO && offset < MAINT_HI) begin
            region = RG_MAINT;
        end else if (|raz_hit) begin
            region = RG_RAZ;
        end else begin
            case (offset)
                OFF_ID:     region = RG_ID;
                OFF_CTYPE:  region = RG_CTYPE;
                OFF_ENABLE: region = RG_ENABLE;
                OFF_AUX:    region = RG_AUX;
                OFF_TAGLAT: region = RG_TAGLAT;
                OFF_DATLAT: region = RG_DATLAT;
                OFF_FSTART: region = RG_FSTART;
                OFF_FEND:   region = RG_FEND;
                default:    region = RG_BAD;
            endcase
        end
    end

endmodule

// File: rtl/l2stub_cfgregs.sv
module l2stub_cfgregs
    import l2stub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  access_t     acc,
    output logic [31:0] rdata,
    output logic [31:0] aux_value
);

    logic        enable_q;
    logic [31:0] aux_q, taglat_q, datlat_q, fstart_q, fend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            aux_q    <= AUX_RESET;
            taglat_q <= '0;
            datlat_q <= '0;
            fstart_q <= '0;
            fend_q   <= '0;
        end else if (acc.wr) begin
            case (acc.region)
                RG_ENABLE: enable_q <= acc.wdata[0];
                RG_AUX:    aux_q    <= acc.wdata;
                RG_TAGLAT: taglat_q <= acc.wdata;
                RG_DATLAT: datlat_q <= acc.wdata;
                RG_FSTART: fstart_q <= acc.wdata;
                RG_FEND:   fend_q   <= acc.wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (acc.region)
            RG_ENABLE: rdata = {31'd0, enable_q};
            RG_AUX:    rdata = aux_q;
            RG_TAGLAT: rdata = taglat_q;
            RG_DATLAT: rdata = datlat_q;
            RG_FSTART: rdata = fstart_q;
            RG_FEND:   rdata = fend_q;
            default:   rdata = '0;
        endcase
    end

    assign aux_value = aux_q;

    assert_reset_aux_R1: assert property (@(posedge clk)
        rst |=> (aux_q == AUX_RESET && fend_q == '0 && !enable_q));

    assert_write_aux_R4: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.region == RG_AUX) |=> (aux_q == $past(acc.wdata)));

    assert_noacc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> ($stable(aux_q) && $stable(taglat_q) && $stable(fstart_q)));

endmodule

// File: rtl/l2stub_ctype.sv
module l2stub_ctype
    import l2stub_pkg::*;
#(
    parameter logic [31:0] CTYPE_INIT = 32'h1C10_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_hit,
    input  logic [31:0] aux_value,
    output logic [31:0] ctype_rd
);

    logic [31:0] ctype_q;

    assign ctype_rd = ctype_q | ctype_or_mask(aux_value);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctype_q <= CTYPE_INIT;
        end else if (rd_hit) begin
            ctype_q <= ctype_rd;
        end
    end

    assert_sticky_bits_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ctype_q & $past(ctype_q)) == $past(ctype_q)));

    assert_reset_ctype_R1: assert property (@(posedge clk)
        rst |=> (ctype_q == CTYPE_INIT));

endmodule

// File: rtl/l2stub_regblock.sv
module l2stub_regblock
    import l2stub_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] CTYPE_INIT = 32'h1C10_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr
);

    region_e     region;
    access_t     acc;
    logic        in_access;
    logic [31:0] cfg_rdata, aux_value, ctype_rd, rd_mux;

    l2stub_decode u_decode (
        .offset (paddr[OFF_W-1:0]),
        .region (region)
    );

    assign in_access  = psel && penable;
    assign acc.rd     = in_access && !pwrite;
    assign acc.wr     = in_access && pwrite;
    assign acc.region = region;
    assign acc.wdata  = pwdata;

    l2stub_cfgregs u_cfgregs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rdata     (cfg_rdata),
        .aux_value (aux_value)
    );

    l2stub_ctype #(.CTYPE_INIT(CTYPE_INIT)) u_ctype (
        .clk       (clk),
        .rst       (rst),
        .rd_hit    (acc.rd && region == RG_CTYPE),
        .aux_value (aux_value),
        .ctype_rd  (ctype_rd)
    );

    always_comb begin
        case (region)
            RG_ID:    rd_mux = ID_VALUE;
            RG_CTYPE: rd_mux = ctype_rd;
            default:  rd_mux = cfg_rdata;
        endcase
    end

    assign prdata  = acc.rd ? rd_mux : '0;
    assign pready  = 1'b1;
    assign pslverr = in_access && (region == RG_BAD);

    assert_enable_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pwrite && paddr[11:0] == 12'h100) |-> (prdata[31:1] == '0));

    assert_maint_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && paddr[11:0] >= 12'h730 && paddr[11:0] < 12'h800)
        |-> (!pslverr && prdata == '0));

    assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (prdata == '0 && psel && penable));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable) |-> (prdata == '0 && !pslverr && pready));

endmodule

// File: tb/l2stub_regblock_tb.sv
module l2stub_regblock_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference state
    logic [31:0] m_en, m_aux, m_tag, m_dat, m_fs, m_fe, m_ct;

    always #10 clk = ~clk;

    l2stub_regblock u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic model_reset();
        m_en = 0; m_aux = 32'h0202_0000; m_tag = 0; m_dat = 0;
        m_fs = 0; m_fe = 0; m_ct = 32'h1C10_0100;
    endtask

    task automatic check(input string tag, input logic [31:0] exp_d, input logic exp_e);
        vectors++;
        if (prdata !== exp_d || pslverr !== exp_e || pready !== 1'b1) begin
            errors++;
            $display("FAIL %s: prdata=%h pslverr=%b pready=%b expected prdata=%h pslverr=%b pready=1",
                     tag, prdata, pslverr, pready, exp_d, exp_e);
        end
    endtask

    function automatic logic [31:0] ct_extra(input logic [31:0] a);
        logic [31:0] r;
        r = 0;
        r[18] = a[16]; r[20] = a[17]; r[21] = a[18]; r[22] = a[19];
        r[6]  = a[16]; r[8]  = a[17]; r[9]  = a[18]; r[10] = a[19];
        return r;
    endfunction

    // full APB transfer; compares outputs on each cycle
    task automatic xfer(input string tag, input logic [31:0] addr, input logic wr,
                        input logic [31:0] data);
        int off;
        logic [31:0] ed;
        logic ee;
        off = int'(addr[11:0]);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = data;
        #2 check({tag, " R9 setup"}, 32'h0, 1'b0);
        @(negedge clk);
        penable = 1;
        ed = 0; ee = 0;
        if (off >= 'h730 && off <= 'h7FF) ee = 0;
        else if (off == 'hF40 || off == 'hF60 || off == 'hF80) ee = 0;
        else if (off == 'h000) ed = 32'h4100_00C8;
        else if (off == 'h004) ed = m_ct | ct_extra(m_aux);
        else if (off == 'h100) ed = m_en;
        else if (off == 'h104) ed = m_aux;
        else if (off == 'h108) ed = m_tag;
        else if (off == 'h10C) ed = m_dat;
        else if (off == 'hC00) ed = m_fs;
        else if (off == 'hC04) ed = m_fe;
        else ee = 1;
        #2 check(tag, wr ? 32'h0 : ed, ee);
        if (!wr && off == 'h004) m_ct = ed;
        if (wr) begin
            case (off)
                'h100: m_en  = {31'd0, data[0]};
                'h104: m_aux = data;
                'h108: m_tag = data;
                'h10C: m_dat = data;
                'hC00: m_fs  = data;
                'hC04: m_fe  = data;
                default: ;
            endcase
        end
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        #2 check({tag, " R9 idle"}, 32'h0, 1'b0);
    endtask

    task automatic read_all(input string tag);
        xfer(tag, 32'h100, 0, 0); xfer(tag, 32'h104, 0, 0);
        xfer(tag, 32'h108, 0, 0); xfer(tag, 32'h10C, 0, 0);
        xfer(tag, 32'hC00, 0, 0); xfer(tag, 32'hC04, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_reset();
        #2 check("R1 after reset", 32'h0, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: simulation hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        read_all("R1 reset");
        xfer("R1 ctype reset", 32'h004, 0, 0);
        // R2 id and aliasing
        xfer("R2 id", 32'h000, 0, 0);
        xfer("R2 id alias", 32'hABC5_5000, 0, 0);
        xfer("R2 alias write", 32'h7731_1108, 1, 32'hCAFE_0001);
        xfer("R2 alias read", 32'h108, 0, 0);
        // R3 enable keeps bit 0
        xfer("R3 en wr", 32'h100, 1, 32'hFFFF_FFFF);
        xfer("R3 en rd", 32'h100, 0, 0);
        xfer("R3 en wr0", 32'h100, 1, 32'hFFFF_FFFE);
        xfer("R3 en rd0", 32'h100, 0, 0);
        // R4 full-width registers
        xfer("R4 aux", 32'h104, 1, 32'hA5A5_5A5A);
        xfer("R4 tag", 32'h108, 1, 32'h1234_5678);
        xfer("R4 dat", 32'h10C, 1, 32'hFFFF_FFFF);
        xfer("R4 fs", 32'hC00, 1, 32'h8000_0001);
        xfer("R4 fe", 32'hC04, 1, 32'h0F0F_F0F0);
        read_all("R4 readback");
        // R5 accumulation
        xfer("R5 aux a", 32'h104, 1, 32'h0001_0000);
        xfer("R5 ct a", 32'h004, 0, 0);
        xfer("R5 aux b", 32'h104, 1, 32'h000E_0000);
        xfer("R5 ct b", 32'h004, 0, 0);
        xfer("R5 aux clr", 32'h104, 1, 32'h0000_0000);
        xfer("R5 ct kept", 32'h004, 0, 0);
        xfer("R5 ct again", 32'h004, 0, 0);
        // R6 maintenance range and edges
        xfer("R6 lo wr", 32'h730, 1, 32'hFFFF_FFFF);
        xfer("R6 lo rd", 32'h730, 0, 0);
        xfer("R6 mid rd", 32'h774, 0, 0);
        xfer("R6 hi wr", 32'h7FF, 1, 32'h1);
        xfer("R6 hi rd", 32'h7FC, 0, 0);
        xfer("R6 R8 below", 32'h72C, 0, 0);
        xfer("R6 R8 above", 32'h800, 1, 32'h5);
        // R7 read-zero offsets
        xfer("R7 f40", 32'hF40, 1, 32'hFFFF_FFFF);
        xfer("R7 f60", 32'hF60, 0, 0);
        xfer("R7 f80", 32'hF80, 0, 0);
        xfer("R7 R8 f44", 32'hF44, 0, 0);
        // R8 bad writes change nothing
        xfer("R8 bad wr", 32'h110, 1, 32'hDEAD_BEEF);
        xfer("R8 bad wr2", 32'h101, 1, 32'hDEAD_BEEF);
        xfer("R8 bad rd", 32'hFFC, 0, 0);
        read_all("R8 unchanged");
        // R10 setup phase only
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = 32'h104; pwdata = 32'h7777_7777;
        #2 check("R10 setup only", 32'h0, 1'b0);
        @(negedge clk);
        psel = 0; pwrite = 0;
        #2 check("R10 idle", 32'h0, 1'b0);
        xfer("R10 aux held", 32'h104, 0, 0);
        // R1 reset mid-run
        xfer("R1 prep", 32'h100, 1, 32'h1);
        do_reset();
        read_all("R1 reset again");
        xfer("R1 ctype again", 32'h004, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule